// File: doc/BRIEF.md
# Octant-folded four-quadrant arctangent

This block turns a Cartesian pair into a signed phase word: it computes atan2(y, x) where y is the beta component and x is the alpha component of a positive-sequence voltage vector, as produced by a quadrature filter stage ahead of it. The result is used wherever a grid angle is needed at every sample instant, without waiting for a tracking loop to settle.

Only one eighth of the circle is stored. A 2^IDX_W-entry read-only table holds arctan(u) for u in [0, 1], which covers angles from 0 to a quarter of π. Each sample is folded into that range and then unfolded. The block takes the magnitudes of both inputs, divides the smaller by the larger in a pipelined restoring divider, and looks up the table. It then mirrors the result about π/4 when |y| exceeds |x|, reflects it into the left half-plane when x is negative, and negates it when y is negative. The case where both inputs are zero has no defined angle and is flagged.

The pipeline accepts a new sample on every clock and has a fixed latency.

Top module: `octant_atan2`

## Requirements
- R1: out_valid rises exactly LAT = IDX_W + 3 clock cycles (11 with defaults) after a cycle in which in_valid is sampled high, and stays low otherwise; reset clears out_valid, out_undef and out_angle.
- R2: out_angle is a signed PH_W-bit word in which 2^(PH_W-1) stands for π. It equals atan2(y, x) within 24 LSB at default widths, because the table index is the ratio of the smaller to the larger magnitude scaled to 0..2^IDX_W-1 and rounded to nearest.
- R3: For x > 0 the result is arctan(y/x), in the open range (-π/2, π/2); a positive x with y = 0 gives exactly 0.
- R4: For x < 0 and y >= 0 the result is arctan(y/x) + π. A value of exactly π (y = 0) is reported as -2^(PH_W-1), the same angle.
- R5: For x < 0 and y < 0 the result is arctan(y/x) - π.
- R6: For x = 0 the result is exactly +2^(PH_W-2) (π/2) when y > 0 and exactly -2^(PH_W-2) when y < 0.
- R7: For |x| = |y| non-zero the result is exactly an odd multiple of 2^(PH_W-3): +8192, +24576, -24576 or -8192 (defaults) for the four quadrants.
- R8: When x = 0 and y = 0, out_undef is 1 and out_angle is 0; for any other input out_undef is 0.
- R9: Samples presented on consecutive cycles each produce a result, in the same order, on consecutive cycles.
- R10: The most negative input code -2^(IN_W-1) on either input is handled as magnitude 2^(IN_W-1); for example x = y = -32768 gives -24576 and x = -32768, y = 0 gives -32768.
- R11: For y > 0 the result lies in [0, π] (π encoded as -2^(PH_W-1)). For y < 0 it lies in [-π, 0], that is, sign bit set or exactly zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe for in_x and in_y |
| in_x | input | IN_W | Alpha component, two's complement |
| in_y | input | IN_W | Beta component, two's complement |
| out_valid | output | 1 | Result strobe, LAT cycles after in_valid |
| out_angle | output | PH_W | Phase, 2^(PH_W-1) = π, two's complement |
| out_undef | output | 1 | Both inputs were zero; angle forced to 0 |

## Verification
The angle is checked with points on all four axes and on the four diagonals. These give exact codes, so they separate a wrong quadrant mirror, a wrong swap about π/4 or an off-by-one table entry from ordinary lookup error. Off-axis points in every octant, including ratios near 0 and near 1, are compared against a real-valued atan2 within the stated tolerance, which exposes a broken divider bit or a wrong rounding step. Inputs at the most negative code show whether the magnitude logic handles the one value with no positive twin. A back-to-back stream of exact points shows ordering and the fixed latency, and the zero-zero input tells the undefined flag apart from a true zero angle.

// File: rtl/oatan_pkg.sv
package oatan_pkg;

  // Sideband carried along the divider pipeline with each sample
  typedef struct packed {
    logic vld;   // sample present
    logic xneg;  // alpha was negative
    logic yneg;  // beta was negative
    logic swp;   // |y| > |x|: ratio was inverted
  } side_t;

endpackage

// File: rtl/oat_fold.sv
// Stage 0: magnitudes, octant decision and the divider operands.
module oat_fold #(
  parameter int IN_W  = 16,
  parameter int IDX_W = 8,
  localparam int MAG_W = IN_W,
  localparam int NUM_W = MAG_W + IDX_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [IN_W-1:0]       in_x,
  input  logic [IN_W-1:0]       in_y,
  output oatan_pkg::side_t      side_o,
  output logic [NUM_W-1:0]      num_o,
  output logic [NUM_W-1:0]      den_o
);
  localparam int SCALE = (2 ** IDX_W) - 1;

  logic [MAG_W-1:0] ax, ay, mn, mx;
  logic             swp;

  always_comb begin
    ax  = in_x[IN_W-1] ? (MAG_W'(~in_x) + MAG_W'(1)) : MAG_W'(in_x);
    ay  = in_y[IN_W-1] ? (MAG_W'(~in_y) + MAG_W'(1)) : MAG_W'(in_y);
    swp = (ay > ax);
    mn  = swp ? ax : ay;
    mx  = swp ? ay : ax;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      side_o <= '0;
      num_o  <= '0;
      den_o  <= '0;
    end else begin
      side_o.vld  <= in_valid;
      side_o.xneg <= in_x[IN_W-1];
      side_o.yneg <= in_y[IN_W-1];
      side_o.swp  <= swp;
      num_o       <= NUM_W'(mn) * NUM_W'(SCALE);
      den_o       <= NUM_W'(mx);
    end
  end
endmodule

// File: rtl/oat_div_stage.sv
// One restoring-division step: decides quotient bit BIT.
module oat_div_stage #(
  parameter int NUM_W = 24,
  parameter int IDX_W = 8,
  parameter int BIT   = 0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  oatan_pkg::side_t      side_i,
  input  logic [NUM_W-1:0]      rem_i,
  input  logic [NUM_W-1:0]      den_i,
  input  logic [IDX_W-1:0]      q_i,
  output oatan_pkg::side_t      side_o,
  output logic [NUM_W-1:0]      rem_o,
  output logic [NUM_W-1:0]      den_o,
  output logic [IDX_W-1:0]      q_o
);
  logic [NUM_W-1:0] trial, rem_n;
  logic [IDX_W-1:0] q_n;
  logic             ge;

  always_comb begin
    trial  = den_i << BIT;
    ge     = (rem_i >= trial);
    rem_n  = ge ? (rem_i - trial) : rem_i;
    q_n    = q_i;
    q_n[BIT] = ge;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      side_o <= '0;
      rem_o  <= '0;
      den_o  <= '0;
      q_o    <= '0;
    end else begin
      side_o <= side_i;
      rem_o  <= rem_n;
      den_o  <= den_i;
      q_o    <= q_n;
    end
  end
endmodule

// File: rtl/oat_rom.sv
// Eighth-circle arctangent table, read synchronously (block RAM friendly).
module oat_rom #(
  parameter int IDX_W = 8,
  parameter int PH_W  = 16,
  parameter int NUM_W = 24
) (
  input  logic                  clk,
  input  logic                  rst,
  input  oatan_pkg::side_t      side_i,
  input  logic [IDX_W-1:0]      q_i,
  input  logic [NUM_W-1:0]      rem_i,
  input  logic [NUM_W-1:0]      den_i,
  output oatan_pkg::side_t      side_o,
  output logic                  undef_o,
  output logic [PH_W-1:0]       base_o
);
  localparam int  DEPTH   = 2 ** IDX_W;
  localparam real PI_R    = 3.14159265358979;
  localparam real SCALE_R = (2.0 ** (PH_W - 1)) / PI_R;

  logic [PH_W-1:0]  mem [DEPTH];
  logic [IDX_W-1:0] addr;
  logic             up;

  initial begin : fill_tab
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = PH_W'($rtoi($atan(real'(i) / real'(DEPTH - 1)) * SCALE_R + 0.5));
    end
  end

  // Round the quotient to nearest; it never exceeds DEPTH-1 because a
  // quotient of DEPTH-1 only occurs with equal magnitudes and no remainder.
  always_comb begin
    up   = ({rem_i, 1'b0} >= {1'b0, den_i});
    addr = q_i + IDX_W'(up);
  end

  always_ff @(posedge clk) begin
    base_o <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      side_o  <= '0;
      undef_o <= 1'b0;
    end else begin
      side_o  <= side_i;
      undef_o <= (den_i == '0);
    end
  end
endmodule

// File: rtl/oat_unfold.sv
// Octant reconstruction: mirror about pi/4, then x < 0 and y < 0 reflections.
module oat_unfold #(
  parameter int PH_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  oatan_pkg::side_t      side_i,
  input  logic                  undef_i,
  input  logic [PH_W-1:0]       base_i,
  output logic                  out_valid,
  output logic [PH_W-1:0]       out_angle,
  output logic                  out_undef
);
  localparam logic [PH_W:0] QUARTER = (PH_W+1)'(2 ** (PH_W - 2));
  localparam logic [PH_W:0] HALF    = (PH_W+1)'(2 ** (PH_W - 1));

  logic [PH_W:0]   a1, a2, a3;
  logic [PH_W-1:0] ang;

  always_comb begin
    a1  = side_i.swp  ? (QUARTER - {1'b0, base_i}) : {1'b0, base_i};
    a2  = side_i.xneg ? (HALF - a1) : a1;
    a3  = side_i.yneg ? ((PH_W+1)'(0) - a2) : a2;
    ang = undef_i ? '0 : a3[PH_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_angle <= '0;
      out_undef <= 1'b0;
    end else begin
      out_valid <= side_i.vld;
      out_angle <= ang;
      out_undef <= side_i.vld & undef_i;
    end
  end
endmodule

// File: rtl/octant_atan2.sv
module octant_atan2 #(
  parameter int IN_W  = 16,
  parameter int PH_W  = 16,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_x,
  input  logic [IN_W-1:0]  in_y,
  output logic             out_valid,
  output logic [PH_W-1:0]  out_angle,
  output logic             out_undef
);
  localparam int NUM_W = IN_W + IDX_W;
  localparam int LAT   = IDX_W + 3;

  oatan_pkg::side_t side_c [IDX_W+1];
  logic [NUM_W-1:0] rem_c  [IDX_W+1];
  logic [NUM_W-1:0] den_c  [IDX_W+1];
  logic [IDX_W-1:0] q_c    [IDX_W+1];

  oatan_pkg::side_t side_r;
  logic             undef_r;
  logic [PH_W-1:0]  base_r;

  oat_fold #(.IN_W(IN_W), .IDX_W(IDX_W)) u_fold (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .side_o(side_c[0]), .num_o(rem_c[0]), .den_o(den_c[0])
  );

  assign q_c[0] = '0;

  for (genvar g = 0; g < IDX_W; g++) begin : g_div
    oat_div_stage #(.NUM_W(NUM_W), .IDX_W(IDX_W), .BIT(IDX_W - 1 - g)) u_st (
      .clk(clk), .rst(rst),
      .side_i(side_c[g]),   .rem_i(rem_c[g]),   .den_i(den_c[g]),   .q_i(q_c[g]),
      .side_o(side_c[g+1]), .rem_o(rem_c[g+1]), .den_o(den_c[g+1]), .q_o(q_c[g+1])
    );
  end

  oat_rom #(.IDX_W(IDX_W), .PH_W(PH_W), .NUM_W(NUM_W)) u_rom (
    .clk(clk), .rst(rst), .side_i(side_c[IDX_W]), .q_i(q_c[IDX_W]),
    .rem_i(rem_c[IDX_W]), .den_i(den_c[IDX_W]),
    .side_o(side_r), .undef_o(undef_r), .base_o(base_r)
  );

  oat_unfold #(.PH_W(PH_W)) u_unfold (
    .clk(clk), .rst(rst), .side_i(side_r), .undef_i(undef_r), .base_i(base_r),
    .out_valid(out_valid), .out_angle(out_angle), .out_undef(out_undef)
  );

  initial begin
    if (LAT != IDX_W + 3) $error("latency bookkeeping mismatch");
  end
endmodule

// File: rtl/oat_check.sv
module oat_check #(
  parameter int IN_W  = 16,
  parameter int PH_W  = 16,
  parameter int IDX_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [IN_W-1:0] in_x,
  input logic [IN_W-1:0] in_y,
  input logic            out_valid,
  input logic [PH_W-1:0] out_angle,
  input logic            out_undef
);
  localparam int LAT = IDX_W + 3;
  localparam logic [PH_W-1:0] QTR  = PH_W'(2 ** (PH_W - 2));
  localparam logic [PH_W-1:0] MINV = PH_W'(2 ** (PH_W - 1));

  // flags: 0 valid, 1 both zero, 2 +x axis, 3 +y axis, 4 y<0, 5 y>0
  logic [5:0] hist [LAT];
  logic [5:0] now_f;
  logic [5:0] d;

  always_comb begin
    now_f[0] = in_valid;
    now_f[1] = in_valid && (in_x == '0) && (in_y == '0);
    now_f[2] = in_valid && (in_y == '0) && ($signed(in_x) > 0);
    now_f[3] = in_valid && (in_x == '0) && ($signed(in_y) > 0);
    now_f[4] = in_valid && in_y[IN_W-1];
    now_f[5] = in_valid && ($signed(in_y) > 0);
    d = hist[LAT-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LAT; i++) hist[i] <= '0;
    end else begin
      hist[0] <= now_f;
      for (int i = 1; i < LAT; i++) hist[i] <= hist[i-1];
    end
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid == d[0]);

  assert_undef_flag_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_undef == d[1]));

  assert_undef_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_undef) |-> (out_angle == '0));

  assert_xaxis_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && d[2]) |-> (out_angle == '0));

  assert_yaxis_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && d[3]) |-> (out_angle == QTR));

  assert_neg_half_R11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && d[4]) |-> (out_angle[PH_W-1] || out_angle == '0));

  assert_pos_half_R11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && d[5]) |-> (!out_angle[PH_W-1] || out_angle == MINV));
endmodule

bind octant_atan2 oat_check #(.IN_W(IN_W), .PH_W(PH_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
  .out_valid(out_valid), .out_angle(out_angle), .out_undef(out_undef)
);

// File: tb/octant_atan2_test.sv
module octant_atan2_test;
  localparam int IN_W = 16;
  localparam int PH_W = 16;
  localparam int IDX_W = 8;
  localparam int LAT = IDX_W + 3;
  localparam int TOL = 24;
  localparam real PI_R = 3.14159265358979;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [IN_W-1:0] in_x = '0;
  logic [IN_W-1:0] in_y = '0;
  logic out_valid;
  logic [PH_W-1:0] out_angle;
  logic out_undef;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  octant_atan2 #(.IN_W(IN_W), .PH_W(PH_W), .IDX_W(IDX_W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .out_valid(out_valid), .out_angle(out_angle), .out_undef(out_undef)
  );

  function automatic int ref_angle(int x, int y);
    real r;
    int v;
    r = $atan2(real'(y), real'(x)) * 32768.0 / PI_R;
    v = (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
    if (v >= 32768) v = v - 65536;
    return v;
  endfunction

  function automatic int sang();
    return int'($signed(out_angle));
  endfunction

  task automatic chk_eq(string req, string what, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic chk_near(string req, int x, int y, int got, int exp);
    int d;
    total++;
    d = (got - exp) & 16'hFFFF;
    if (d >= 32768) d = d - 65536;
    if (d > TOL || d < -TOL) begin
      bad++;
      $display("FAIL %s angle(x=%0d,y=%0d): got %0d expected %0d +/- %0d",
               req, x, y, got, exp, TOL);
    end
  endtask

  // one isolated sample; returns with outputs of that sample visible
  task automatic run_one(int x, int y);
    @(negedge clk);
    in_x = IN_W'(x); in_y = IN_W'(y); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (LAT - 1) @(negedge clk);
  endtask

  task automatic exact(string req, int x, int y, int exp);
    run_one(x, y);
    chk_eq(req, "valid", int'(out_valid), 1);
    chk_eq(req, $sformatf("angle(x=%0d,y=%0d)", x, y), sang(), exp);
    chk_eq("R8", "undef clear", int'(out_undef), 0);
  endtask

  task automatic near(string req, int x, int y);
    run_one(x, y);
    chk_near(req, x, y, sang(), ref_angle(x, y));
  endtask

  task automatic t_reset;
    chk_eq("R1", "reset valid", int'(out_valid), 0);
    chk_eq("R1", "reset angle", sang(), 0);
    chk_eq("R1", "reset undef", int'(out_undef), 0);
  endtask

  task automatic t_latency;
    @(negedge clk);
    in_x = 16'd300; in_y = 16'd100; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (LAT - 2) @(negedge clk);
    chk_eq("R1", "valid one cycle early", int'(out_valid), 0);
    @(negedge clk);
    chk_eq("R1", "valid at latency", int'(out_valid), 1);
    @(negedge clk);
    chk_eq("R1", "valid one cycle late", int'(out_valid), 0);
  endtask

  task automatic t_axes;
    exact("R3", 1000, 0, 0);
    exact("R6", 0, 1000, 16384);
    exact("R6", 0, -7, -16384);
    exact("R4", -1000, 0, -32768);
  endtask

  task automatic t_diag;
    exact("R7", 500, 500, 8192);
    exact("R7", -500, 500, 24576);
    exact("R7", -500, -500, -24576);
    exact("R7", 500, -500, -8192);
  endtask

  task automatic t_quadrants;
    near("R3", 30000, 1234);
    near("R3", 12000, -11000);
    near("R2", 1000, 2999);
    near("R2", -321, 9999);
    near("R4", -20000, 7000);
    near("R4", -3, 2);
    near("R5", -15000, -14999);
    near("R5", -123, -4567);
    near("R2", 777, -32000);
    near("R2", 32767, 32766);
  endtask

  task automatic t_undef;
    run_one(0, 0);
    chk_eq("R8", "undef set", int'(out_undef), 1);
    chk_eq("R8", "undef angle", sang(), 0);
    run_one(0, 1);
    chk_eq("R8", "undef after non-zero", int'(out_undef), 0);
  endtask

  task automatic t_fullscale;
    exact("R10", -32768, -32768, -24576);
    exact("R10", -32768, 0, -32768);
    exact("R10", 0, -32768, -16384);
    near("R10", 32767, -32768);
  endtask

  task automatic t_sign;
    run_one(32767, -1);
    total++;
    if (!(out_angle[PH_W-1] || out_angle == '0)) begin
      bad++;
      $display("FAIL R11 y<0 sign: got %0d expected <= 0", sang());
    end
    run_one(-32000, 1);
    total++;
    if (out_angle[PH_W-1] && out_angle != 16'h8000) begin
      bad++;
      $display("FAIL R11 y>0 sign: got %0d expected in [0,pi]", sang());
    end
  endtask

  task automatic t_stream;
    int xs[6] = '{100, 0, -100, 0, 50, -50};
    int ys[6] = '{0, 100, 0, -100, 50, -50};
    int ex[6] = '{0, 16384, -32768, -16384, 8192, -24576};
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      in_x = IN_W'(xs[k]); in_y = IN_W'(ys[k]); in_valid = 1'b1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (LAT - 6) @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      chk_eq("R9", $sformatf("stream valid %0d", k), int'(out_valid), 1);
      chk_eq("R9", $sformatf("stream angle %0d", k), sang(), ex[k]);
      @(negedge clk);
    end
    chk_eq("R9", "stream ends", int'(out_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_latency();
    t_axes();
    t_diag();
    t_quadrants();
    t_undef();
    t_fullscale();
    t_sign();
    t_stream();
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule